// File: doc/BRIEF.md
# HDLC Receive Frame Check and Status

This block follows an HDLC receiver once zero-bit deletion is done. A serial stream of de-stuffed bits enters one bit per strobed cycle, least significant bit of each octet first. Two frame check sequence engines run side by side over every frame: a 16-bit one and a 32-bit one. A strobe from the flag detector marks the opening flag, and a second strobe marks the closing flag. When the closing flag arrives, each engine that the selected mode enables compares its register with the residue that an error-free frame leaves behind. On a mismatch it raises a sticky error bit.

The result sits in an eight-bit status byte that software can only read. The upper two bits carry the check results. The lower six bits latch event pulses that sibling detectors report: transmit underrun, receive overrun, invalid frame, abort, idle and flag. Any read of the byte clears every bit. A single interrupt line is raised while any status bit is set whose enable bit is also set.

Top module: `hdlc_rx_crc_status`

## Requirements
- R1: After reset, `status` is 0x00 and `irq` is low.
- R2: The 16-bit check uses the bit-reversed polynomial 0x8408, with bits taken LSB first and a preset of 0xFFFF. When the closing flag is seen, `status[6]` is set if the register is not 0xF0B8 and `mode_sel` is 2'b01 (16-bit) or 2'b11 (search).
- R3: The 32-bit check uses the bit-reversed polynomial 0xEDB88320, with bits taken LSB first and a preset of all ones. When the closing flag is seen, `status[7]` is set if the register is not 0xDEBB20E3 and `mode_sel` is 2'b10 (32-bit) or 2'b11 (search).
- R4: With `mode_sel` 2'b00, a closing flag sets neither check bit. 16-bit mode never sets `status[7]`, and 32-bit mode never sets `status[6]`.
- R5: A frame of fewer than 16 accepted bits is reported invalid for the 16-bit check, and a frame of fewer than 32 bits is reported invalid for the 32-bit check, whatever the register holds.
- R6: `frame_start` presets both engines and the bit count. When `frame_start` and `frame_end` are high in the same cycle, the old frame is judged first and the new frame starts clean.
- R7: A high bit in `evt_in[5:0]` sets the same bit of `status`. The order from bit 5 down to bit 0 is: tx underrun, rx overrun, invalid frame, abort, idle, flag.
- R8: Status bits stay set until a read. While `stat_rd` is high, `status` still shows the value from before the read. From the next clock edge, every bit is clear.
- R9: If a set event and a read fall in the same cycle, the new event's bit is set after that edge.
- R10: `irq` is high exactly while `status & irq_en` is nonzero. It follows a change of `irq_en` with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | Check mode: 00 off, 01 16-bit, 10 32-bit, 11 search (both) |
| frame_start | input | 1 | Opening flag seen; presets the engines |
| bit_valid | input | 1 | Strobe for one de-stuffed data bit |
| bit_data | input | 1 | De-stuffed data bit |
| frame_end | input | 1 | Closing flag seen; judges the frame |
| evt_in | input | 6 | Event pulses for status bits 5..0 |
| stat_rd | input | 1 | Status read strobe; clears on the following edge |
| irq_en | input | 8 | Per-bit interrupt enables |
| status | output | 8 | Sticky status byte |
| irq | output | 1 | New-status interrupt |

## Verification
The bench uses the default count width of six bits. This width is enough to hold the 32-bit minimum, so frames of exactly 16 and exactly 32 bits fall right on the short-frame boundary. The vector table drives each mode against good, swapped-width and corrupted check sequences, as well as empty and one-octet frames. The directed tests cover back-to-back frames that share a flag, a read colliding with an event, and masking of the interrupt.

// File: rtl/hdlc_rx_crc_status.sv
module hdlc_rx_crc_status #(
  parameter int CNT_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       frame_start,
  input  logic       bit_valid,
  input  logic       bit_data,
  input  logic       frame_end,
  input  logic [5:0] evt_in,
  input  logic       stat_rd,
  input  logic [7:0] irq_en,
  output logic [7:0] status,
  output logic       irq
);
  localparam logic [15:0] POLY16 = 16'h8408;
  localparam logic [15:0] GOOD16 = 16'hF0B8;
  localparam logic [31:0] POLY32 = 32'hEDB88320;
  localparam logic [31:0] GOOD32 = 32'hDEBB20E3;
  localparam logic [CNT_W-1:0] MIN16 = CNT_W'(16);
  localparam logic [CNT_W-1:0] MIN32 = CNT_W'(32);

  logic [15:0] crc16_q;
  logic [31:0] crc32_q;
  logic [CNT_W-1:0] nbits_q;
  logic [7:0] status_q;

  wire fb16 = crc16_q[0] ^ bit_data;
  wire fb32 = crc32_q[0] ^ bit_data;
  wire [15:0] crc16_n = (crc16_q >> 1) ^ (fb16 ? POLY16 : 16'h0);
  wire [31:0] crc32_n = (crc32_q >> 1) ^ (fb32 ? POLY32 : 32'h0);

  wire bad16 = frame_end && mode_sel[0] && (crc16_q != GOOD16 || nbits_q < MIN16);
  wire bad32 = frame_end && mode_sel[1] && (crc32_q != GOOD32 || nbits_q < MIN32);
  wire [7:0] set_vec = {bad32, bad16, evt_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc16_q <= '1;
      crc32_q <= '1;
      nbits_q <= '0;
    end else if (frame_start) begin
      crc16_q <= '1;
      crc32_q <= '1;
      nbits_q <= '0;
    end else if (bit_valid) begin
      crc16_q <= crc16_n;
      crc32_q <= crc32_n;
      if (nbits_q != MIN32) nbits_q <= nbits_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= 8'h00;
    else        status_q <= (stat_rd ? 8'h00 : status_q) | set_vec;
  end

  assign status = status_q;
  assign irq    = |(status_q & irq_en);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((status_q & $past(status_q)) == $past(status_q)));
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && evt_in == 6'h0 && !frame_end) |=> (status_q == 8'h00));
  a_r7_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_in != 6'h0) |=> ((status_q[5:0] & $past(evt_in)) == $past(evt_in)));
  a_r4_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00 && !stat_rd) |=> $stable(status_q[7:6]));
  a_r4_mode16_no32: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01 && !stat_rd) |=> $stable(status_q[7]));
  a_r4_mode32_no16: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b10 && !stat_rd) |=> $stable(status_q[6]));
  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == 8'h00) |-> !irq);
endmodule

// File: tb/hdlc_rx_crc_status_bench.sv
`timescale 1ns/1ps
module hdlc_rx_crc_status_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic frame_start = 0, bit_valid = 0, bit_data = 0, frame_end = 0, stat_rd = 0;
  logic [5:0] evt_in = '0;
  logic [7:0] irq_en = '0;
  logic [7:0] status;
  logic irq;
  int checks = 0, errors = 0;
  logic [7:0] buf_b [0:15];
  int nbytes;

  always #2.5 clk = ~clk;

  hdlc_rx_crc_status u_hdlc_rx_crc_status (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .frame_start(frame_start),
    .bit_valid(bit_valid), .bit_data(bit_data), .frame_end(frame_end),
    .evt_in(evt_in), .stat_rd(stat_rd), .irq_en(irq_en), .status(status), .irq(irq));

  // entry: mode[11:10] kind[9:8] len[7:4] pad[3:2] exp{b7,b6}[1:0]
  // kind: 0 no FCS, 1 good 16-bit FCS, 2 good 32-bit FCS, 3 16-bit FCS with a flipped bit
  localparam int NV = 14;
  localparam logic [11:0] VEC [NV] = '{
    {2'b01, 2'd1, 4'd4, 2'b00, 2'b00}, {2'b01, 2'd2, 4'd4, 2'b00, 2'b01},
    {2'b10, 2'd2, 4'd5, 2'b00, 2'b00}, {2'b10, 2'd1, 4'd5, 2'b00, 2'b10},
    {2'b11, 2'd1, 4'd3, 2'b00, 2'b10}, {2'b11, 2'd2, 4'd3, 2'b00, 2'b01},
    {2'b00, 2'd3, 4'd4, 2'b00, 2'b00}, {2'b01, 2'd3, 4'd4, 2'b00, 2'b01},
    {2'b11, 2'd0, 4'd0, 2'b00, 2'b11}, {2'b10, 2'd0, 4'd1, 2'b00, 2'b10},
    {2'b01, 2'd1, 4'd0, 2'b00, 2'b00}, {2'b10, 2'd2, 4'd0, 2'b00, 2'b00},
    {2'b11, 2'd3, 4'd6, 2'b00, 2'b11}, {2'b10, 2'd1, 4'd2, 2'b00, 2'b10}};

  task automatic tick(); @(negedge clk); endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc16_of(int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++)
        c = (c[0] ^ buf_b[i][b]) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    return c;
  endfunction

  function automatic logic [31:0] crc32_of(int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++)
        c = (c[0] ^ buf_b[i][b]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return c;
  endfunction

  task automatic build(int kind, int len, int seed);
    logic [15:0] f16;
    logic [31:0] f32;
    for (int i = 0; i < len; i++) buf_b[i] = 8'((seed + i * 37) & 8'hFF);
    nbytes = len;
    if (kind == 1 || kind == 3) begin
      f16 = ~crc16_of(len);
      if (kind == 3) f16[0] = ~f16[0];
      buf_b[len] = f16[7:0]; buf_b[len+1] = f16[15:8];
      nbytes = len + 2;
    end else if (kind == 2) begin
      f32 = ~crc32_of(len);
      for (int k = 0; k < 4; k++) buf_b[len+k] = f32[8*k +: 8];
      nbytes = len + 4;
    end
  endtask

  task automatic send_bits();
    for (int i = 0; i < nbytes; i++)
      for (int b = 0; b < 8; b++) begin
        bit_valid = 1; bit_data = buf_b[i][b]; tick();
      end
    bit_valid = 0; bit_data = 0;
  endtask

  task automatic do_read();
    stat_rd = 1; tick(); stat_rd = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    string tag;
    tick(); tick(); rst_n = 1; tick();
    check("R1 status", status, 8'h00);
    check("R1 irq", irq, 0);

    for (int v = 0; v < NV; v++) begin
      logic [11:0] e = VEC[v];
      tag = (e[9:8] == 2'd0) ? "R5" : (e[11:10] == 2'b00) ? "R4" :
            (e[11:10] == 2'b10) ? "R3" : "R2";
      mode_sel = e[11:10];
      build(int'(e[9:8]), int'(e[7:4]), v * 11 + 3);
      frame_start = 1; tick(); frame_start = 0;
      send_bits();
      frame_end = 1; tick(); frame_end = 0;
      check($sformatf("%s vec%0d", tag, v), status, {e[1:0], 6'h00});
      do_read();
      check($sformatf("R8 vec%0d cleared", v), status, 8'h00);
    end

    // R7 / R10 / R8
    mode_sel = 2'b00;
    evt_in = 6'b100001; tick(); evt_in = '0;
    check("R7 events latched", status, 8'h21);
    check("R10 irq masked", irq, 0);
    irq_en = 8'h01; #1;
    check("R10 irq enabled", irq, 1);
    irq_en = 8'h80; #1;
    check("R10 irq other enable", irq, 0);
    tick();
    check("R8 sticky", status, 8'h21);
    stat_rd = 1; #1;
    check("R8 pre-clear value", status, 8'h21);
    tick(); stat_rd = 0;
    check("R8 cleared", status, 8'h00);

    // R9 collision
    evt_in = 6'b100001; tick();
    stat_rd = 1; evt_in = 6'b000100; tick(); stat_rd = 0; evt_in = '0;
    check("R9 set wins", status, 8'h04);
    do_read();

    // R6 shared flag: bad frame then good frame
    mode_sel = 2'b01; irq_en = 8'h40;
    build(3, 3, 90);
    frame_start = 1; tick(); frame_start = 0;
    send_bits();
    frame_end = 1; frame_start = 1; tick(); frame_end = 0; frame_start = 0;
    check("R6 old frame judged", status, 8'h40);
    check("R10 irq on crc error", irq, 1);
    do_read();
    build(1, 3, 90);
    send_bits();
    frame_end = 1; tick(); frame_end = 0;
    check("R6 new frame preset", status, 8'h00);
    check("R10 irq low", irq, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule